// File: doc/BRIEF.md
# Write-Once Watchdog Control Unit

This block is a watchdog timer governed by one 8-bit control register. The register holds a window-enable flag, a debug-stop flag and a 3-bit rate field. A free-running counter advances on a clock-enable input, and when it reaches the terminal count set by the rate field it raises a one-cycle reset request. Who may change the register depends on the operating mode. In normal mode the rate field and the window flag accept a single write, and that write counts even when it changes nothing. In special mode they can be rewritten at will. The debug-stop flag can only be set in normal mode.

After reset the rate field and the window flag are loaded from an initial-value input, and the timeout period begins if the loaded rate is non-zero. Several events restart the period: permitted register writes, a change of the clock-source selection, and loss of the oscillator while the oscillator is the selected source. In stop mode the counter keeps running or halts depending on the selected source, the pseudo-stop flag and an oscillator-enable input.

Top module: `wdt_lock_top`

## Requirements
- R1: Readback places the window flag in bit 7, the debug-stop flag in bit 6 and the rate field in bits 2:0. Bit 5 is a write-side mask bit. Bits 5:3 always read 0.
- R2: During reset the readback is 0x00. On the first clock edge after reset is released, the rate field and window flag take `init_rate`/`init_win`, the debug-stop flag is 0, and a non-zero loaded rate starts a fresh period.
- R3: In normal mode, a write with bit 5 = 0 updates the rate and window fields at most once between resets, and later such writes are ignored. A write with bit 5 = 1 changes neither field and does not use up the single write.
- R4: In normal mode, a rate value of 000 or a window bit of 0 in the permitted write leaves that field unchanged, yet the write still uses up the single write.
- R5: In normal mode, writing 1 to bit 6 sets the debug-stop flag, and writing 0 does not clear it. In special mode, bit 6 takes the written value on every write.
- R6: In special mode, every write with bit 5 = 0 loads bits 7 and 2:0 as written, zero values included, and any write restarts the period, masked writes included.
- R7: In normal mode the period restarts on a permitted write with a non-zero rate, on a permitted write with bit 7 = 1, or on a 0-to-1 change of the debug-stop flag. A permitted write of 0x00 does not restart.
- R8: The period restarts when `clk_sel` changes value. It also restarts when `osc_good` falls while `clk_sel` = 2'b01. An `osc_good` fall under any other selection has no effect.
- R9: With `stop_mode` = 1 the counter halts, except in two cases where it runs: `clk_sel[1]` = 1, or `pseudo_stop` = 1 with `clk_sel` = 2'b01 and `osc_pstop_en` = 1.
- R10: For rate r in 1..7 the request asserts for one cycle after 2^(BASE_EXP+2r) enabled ticks from a restart, counting only cycles with `tick` = 1. Rate 000 disables it. A restart in the same cycle as the terminal count wins, and no request is raised.
- R11: The used-up single write is released only by reset, after which one new normal-mode write is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_special | input | 1 | 1 = special mode, 0 = normal mode |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| init_rate | input | 3 | Rate value loaded after reset |
| init_win | input | 1 | Window flag loaded after reset |
| stop_mode | input | 1 | Device is in stop mode |
| pseudo_stop | input | 1 | Stop mode is the pseudo variant |
| osc_pstop_en | input | 1 | Oscillator kept enabled in pseudo stop |
| clk_sel | input | 2 | Watchdog clock-source selection |
| osc_good | input | 1 | Oscillator status is good |
| tick | input | 1 | Clock enable of the selected source |
| wdt_reset_req | output | 1 | One-cycle timeout reset request |
| reg_rdata | output | 8 | Register readback |

## Verification
A restart event and the terminal count can land on the same clock edge. The bench provokes this by counting idle cycles from the boot load so that a restarting normal-mode write arrives exactly on the edge where the counter holds its last value. The outcome is judged at the ports. No request may appear after that edge, and the next request must come a full period later, which shows that the restart took priority over the timeout.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam int WIN_BIT  = 7;
  localparam int DBG_BIT  = 6;
  localparam int MASK_BIT = 5;
  localparam int RATE_W   = 3;
  localparam int RATE_MAX = 7;

  typedef struct packed {
    logic              win;
    logic              dbg;
    logic [RATE_W-1:0] rate;
  } wdt_cfg_t;

  // Last counter value before the timeout for a given rate.
  function automatic logic [31:0] wdt_last(input logic [RATE_W-1:0] rate,
                                           input int unsigned base_exp);
    int unsigned e;
    e = base_exp + 2 * int'(rate);
    return (32'd1 << e) - 32'd1;
  endfunction

  // Whether the counter may advance under the current low-power state.
  function automatic logic wdt_may_run(input logic stop, input logic pseudo,
                                       input logic osc_pe, input logic [1:0] sel);
    if (!stop)  return 1'b1;
    if (sel[1]) return 1'b1;
    return pseudo && sel[0] && osc_pe;
  endfunction

endpackage

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
  import wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_special,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  input  logic [RATE_W-1:0] init_rate,
  input  logic              init_win,
  output wdt_cfg_t          cfg,
  output logic              lock_q,
  output logic              wr_restart,
  output logic              boot_restart
);

  logic     load_pend;
  logic     fld_ok;
  logic     rate_nz;
  logic     dbg_rise;
  wdt_cfg_t cfg_nxt;

  assign rate_nz  = |wr_data[RATE_W-1:0];
  assign fld_ok   = wr_en && !load_pend && !wr_data[MASK_BIT]
                    && (mode_special || !lock_q);
  assign dbg_rise = wr_en && !load_pend && !cfg.dbg && wr_data[DBG_BIT];

  assign boot_restart = load_pend && (|init_rate);

  always_comb begin
    wr_restart = 1'b0;
    if (!load_pend) begin
      if (mode_special)
        wr_restart = wr_en;
      else
        wr_restart = (fld_ok && (rate_nz || wr_data[WIN_BIT])) || dbg_rise;
    end
  end

  always_comb begin
    cfg_nxt = cfg;
    if (load_pend) begin
      cfg_nxt.rate = init_rate;
      cfg_nxt.win  = init_win;
      cfg_nxt.dbg  = 1'b0;
    end else begin
      if (fld_ok) begin
        if (mode_special) begin
          cfg_nxt.rate = wr_data[RATE_W-1:0];
          cfg_nxt.win  = wr_data[WIN_BIT];
        end else begin
          if (rate_nz)          cfg_nxt.rate = wr_data[RATE_W-1:0];
          if (wr_data[WIN_BIT]) cfg_nxt.win  = 1'b1;
        end
      end
      if (wr_en) begin
        if (mode_special) cfg_nxt.dbg = wr_data[DBG_BIT];
        else              cfg_nxt.dbg = cfg.dbg | wr_data[DBG_BIT];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_pend <= 1'b1;
      cfg       <= '0;
      lock_q    <= 1'b0;
    end else begin
      load_pend <= 1'b0;
      cfg       <= cfg_nxt;
      if (fld_ok && !mode_special) lock_q <= 1'b1;
    end
  end

endmodule

// File: rtl/wdt_src_monitor.sv
module wdt_src_monitor (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] clk_sel,
  input  logic       osc_good,
  output logic       sel_change,
  output logic       osc_loss
);

  logic       seen_q;
  logic [1:0] sel_q;
  logic       osc_q;

  assign sel_change = seen_q && (sel_q != clk_sel);
  assign osc_loss   = seen_q && osc_q && !osc_good && (clk_sel == 2'b01);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      sel_q  <= 2'b00;
      osc_q  <= 1'b0;
    end else begin
      seen_q <= 1'b1;
      sel_q  <= clk_sel;
      osc_q  <= osc_good;
    end
  end

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int BASE_EXP = 12,
  parameter int CW       = BASE_EXP + 2 * RATE_MAX
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] rate,
  input  logic              tick,
  input  logic              run_ok,
  input  logic              restart,
  output logic [CW-1:0]     cnt,
  output logic              at_term,
  output logic              req
);

  logic adv;

  assign adv     = (|rate) && tick && run_ok;
  assign at_term = adv && (32'(cnt) == wdt_last(rate, BASE_EXP));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      req <= 1'b0;
    end else if (restart) begin
      cnt <= '0;
      req <= 1'b0;
    end else if (at_term) begin
      cnt <= '0;
      req <= 1'b1;
    end else begin
      req <= 1'b0;
      if (adv) cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/wdt_lock_top.sv
module wdt_lock_top
  import wdt_pkg::*;
#(
  parameter int BASE_EXP = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mode_special,
  input  logic        wr_en,
  input  logic [7:0]  wr_data,
  input  logic [2:0]  init_rate,
  input  logic        init_win,
  input  logic        stop_mode,
  input  logic        pseudo_stop,
  input  logic        osc_pstop_en,
  input  logic [1:0]  clk_sel,
  input  logic        osc_good,
  input  logic        tick,
  output logic        wdt_reset_req,
  output logic [7:0]  reg_rdata
);

  localparam int CW = BASE_EXP + 2 * RATE_MAX;

  wdt_cfg_t      cfg;
  logic          lock_q;
  logic          wr_restart;
  logic          boot_restart;
  logic          sel_change;
  logic          osc_loss;
  logic          restart;
  logic          run_ok;
  logic          halted;
  logic          at_term;
  logic [CW-1:0] cnt;

  wdt_ctrl_reg u_reg (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_special (mode_special),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .init_rate    (init_rate),
    .init_win     (init_win),
    .cfg          (cfg),
    .lock_q       (lock_q),
    .wr_restart   (wr_restart),
    .boot_restart (boot_restart)
  );

  wdt_src_monitor u_src (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_sel    (clk_sel),
    .osc_good   (osc_good),
    .sel_change (sel_change),
    .osc_loss   (osc_loss)
  );

  assign restart = wr_restart || boot_restart || sel_change || osc_loss;
  assign run_ok  = wdt_may_run(stop_mode, pseudo_stop, osc_pstop_en, clk_sel);
  assign halted  = !run_ok;

  wdt_counter #(.BASE_EXP(BASE_EXP), .CW(CW)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .rate    (cfg.rate),
    .tick    (tick),
    .run_ok  (run_ok),
    .restart (restart),
    .cnt     (cnt),
    .at_term (at_term),
    .req     (wdt_reset_req)
  );

  assign reg_rdata = {cfg.win, cfg.dbg, 3'b000, cfg.rate};

endmodule

// File: rtl/wdt_lock_chk.sv
module wdt_lock_chk #(
  parameter int CW = 26
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mode_special,
  input logic          wr_en,
  input logic [7:0]    reg_rdata,
  input logic          wdt_reset_req,
  input logic          lock_q,
  input logic          restart,
  input logic          halted,
  input logic          at_term,
  input logic [CW-1:0] cnt
);

  p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[5:3] == 3'b000);

  p_once_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_special && lock_q && wr_en) |=>
      ($stable(reg_rdata[2:0]) && $stable(reg_rdata[7])));

  p_dbg_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_special && reg_rdata[6]) |=> reg_rdata[6]);

  p_special_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_special && wr_en) |=> (cnt == '0));

  p_restart_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0 && !wdt_reset_req));

  p_halt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !restart) |=> $stable(cnt));

  p_req_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_reset_req |=> !wdt_reset_req);

  p_req_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (at_term && !restart) |=> wdt_reset_req);

  p_disabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[2:0] == 3'b000) |=> !wdt_reset_req);

endmodule

bind wdt_lock_top wdt_lock_chk #(.CW(CW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .mode_special  (mode_special),
  .wr_en         (wr_en),
  .reg_rdata     (reg_rdata),
  .wdt_reset_req (wdt_reset_req),
  .lock_q        (lock_q),
  .restart       (restart),
  .halted        (halted),
  .at_term       (at_term),
  .cnt           (cnt)
);

// File: tb/wdt_lock_top_tb.sv
module wdt_lock_top_tb;

  localparam int BEXP = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_special = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [2:0] init_rate = 3'd0;
  logic       init_win = 1'b0;
  logic       stop_mode = 1'b0;
  logic       pseudo_stop = 1'b0;
  logic       osc_pstop_en = 1'b0;
  logic [1:0] clk_sel = 2'b00;
  logic       osc_good = 1'b1;
  logic       tick = 1'b1;
  logic       wdt_reset_req;
  logic [7:0] reg_rdata;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  wdt_lock_top #(.BASE_EXP(BEXP)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_special(mode_special), .wr_en(wr_en),
    .wr_data(wr_data), .init_rate(init_rate), .init_win(init_win),
    .stop_mode(stop_mode), .pseudo_stop(pseudo_stop), .osc_pstop_en(osc_pstop_en),
    .clk_sel(clk_sel), .osc_good(osc_good), .tick(tick),
    .wdt_reset_req(wdt_reset_req), .reg_rdata(reg_rdata)
  );

  function automatic int period(input int r);
    return 1 << (BEXP + 2 * r);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge.
  task automatic do_reset(input logic [2:0] r, input logic w);
    rst_n = 1'b0; init_rate = r; init_win = w;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  // Falling edges until the request is seen; -1 if none within maxc.
  task automatic measure(input int maxc, input bit half, output int n);
    n = -1;
    for (int i = 1; i <= maxc; i++) begin
      @(negedge clk);
      if (wdt_reset_req) begin n = i; break; end
      if (half) tick = ~tick;
    end
    tick = 1'b1;
  endtask

  task automatic count_reqs(input int k, output int c);
    c = 0;
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      if (wdt_reset_req) c++;
    end
  endtask

  task automatic t_reset_boot();
    int n;
    rst_n = 1'b0; init_rate = 3'd2; init_win = 1'b1;
    repeat (2) @(negedge clk);
    chk("R2 readback in reset", reg_rdata, 8'h00);
    chk("R2 no request in reset", wdt_reset_req, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 R2 loaded layout", reg_rdata, 8'h82);
    measure(200, 1'b0, n);
    chk("R2 R10 period from boot", n, period(2));
    @(negedge clk);
    chk("R10 request lasts one cycle", wdt_reset_req, 0);
    do_reset(3'd0, 1'b0);
    chk("R2 zero boot readback", reg_rdata, 8'h00);
    measure(300, 1'b0, n);
    chk("R10 rate 000 disabled", n, -1);
  endtask

  task automatic t_once();
    do_reset(3'd0, 1'b0);
    wr(8'h03);
    chk("R3 first write taken", reg_rdata, 8'h03);
    wr(8'h85);
    chk("R3 second write ignored", reg_rdata, 8'h03);
    wr(8'h3c);
    chk("R1 reserved bits read 0", reg_rdata & 8'h38, 0);
  endtask

  task automatic t_mask();
    do_reset(3'd0, 1'b0);
    wr(8'ha5);
    chk("R3 masked write ignored", reg_rdata, 8'h00);
    wr(8'h02);
    chk("R3 mask did not consume", reg_rdata, 8'h02);
  endtask

  task automatic t_zero_lock();
    do_reset(3'd2, 1'b0);
    wr(8'h00);
    chk("R4 zero write no effect", reg_rdata, 8'h02);
    wr(8'h81);
    chk("R4 zero write consumed once", reg_rdata, 8'h02);
  endtask

  task automatic t_dbg();
    do_reset(3'd0, 1'b0);
    wr(8'h40);
    chk("R5 normal set", reg_rdata, 8'h40);
    wr(8'h00);
    chk("R5 normal cannot clear", reg_rdata, 8'h40);
    mode_special = 1'b1;
    wr(8'h00);
    chk("R5 special clears", reg_rdata, 8'h00);
    wr(8'h40);
    chk("R5 special sets", reg_rdata, 8'h40);
    mode_special = 1'b0;
  endtask

  task automatic t_special();
    int n;
    do_reset(3'd0, 1'b0);
    mode_special = 1'b1;
    wr(8'h83);
    chk("R6 first special write", reg_rdata, 8'h83);
    wr(8'h01);
    chk("R6 rewrite incl zero win", reg_rdata, 8'h01);
    wr(8'h27);
    chk("R6 masked keeps fields", reg_rdata, 8'h01);
    wr(8'h02);
    idle(40);
    wr(8'h22);
    measure(200, 1'b0, n);
    chk("R6 masked write restarts", n, period(2));
    mode_special = 1'b0;
  endtask

  task automatic t_normal_restart();
    int n;
    do_reset(3'd2, 1'b0); idle(40); wr(8'h02);
    measure(200, 1'b0, n);
    chk("R7 rate write restarts", n, period(2));
    do_reset(3'd2, 1'b0); idle(40); wr(8'h80);
    measure(200, 1'b0, n);
    chk("R7 window write restarts", n, period(2));
    do_reset(3'd2, 1'b0); idle(40); wr(8'ha0);
    chk("R7 masked window unchanged", reg_rdata, 8'h02);
    idle(0);
    do_reset(3'd2, 1'b0); idle(40); wr(8'h40);
    measure(200, 1'b0, n);
    chk("R7 debug rise restarts", n, period(2));
    do_reset(3'd2, 1'b0); idle(40); wr(8'h00);
    measure(200, 1'b0, n);
    chk("R7 zero write no restart", n, period(2) - 41);
    // collision: restart lands on the terminal edge
    do_reset(3'd2, 1'b0); idle(period(2) - 1); wr(8'h02);
    chk("R10 restart beats timeout", wdt_reset_req, 0);
    measure(200, 1'b0, n);
    chk("R10 full period after collision", n, period(2));
  endtask

  task automatic t_src_restart();
    int n;
    clk_sel = 2'b00;
    do_reset(3'd2, 1'b0); idle(40);
    clk_sel = 2'b10; @(negedge clk);
    measure(200, 1'b0, n);
    chk("R8 select change restarts", n, period(2));
    clk_sel = 2'b01;
    do_reset(3'd2, 1'b0); idle(40);
    osc_good = 1'b0; @(negedge clk);
    measure(200, 1'b0, n);
    chk("R8 osc loss restarts", n, period(2));
    osc_good = 1'b1; clk_sel = 2'b00;
    do_reset(3'd2, 1'b0); idle(40);
    osc_good = 1'b0; @(negedge clk);
    measure(200, 1'b0, n);
    chk("R8 osc loss ignored sel 00", n, period(2) - 41);
    osc_good = 1'b1;
  endtask

  task automatic t_stop();
    int c;
    bit runs;
    for (int s = 0; s < 4; s++) begin
      for (int p = 0; p < 2; p++) begin
        for (int e = 0; e < 2; e++) begin
          clk_sel = 2'(s); pseudo_stop = p[0]; osc_pstop_en = e[0]; stop_mode = 1'b1;
          runs = (s >= 2) || (p == 1 && s == 1 && e == 1);
          do_reset(3'd2, 1'b0);
          count_reqs(100, c);
          chk($sformatf("R9 stop sel=%0d ps=%0d pe=%0d", s, p, e), c, runs ? 1 : 0);
        end
      end
    end
    stop_mode = 1'b0; pseudo_stop = 1'b0; osc_pstop_en = 1'b0; clk_sel = 2'b00;
  endtask

  task automatic t_rate();
    int n;
    do_reset(3'd1, 1'b0);
    measure(200, 1'b0, n);
    chk("R10 rate 1 period", n, period(1));
    measure(200, 1'b0, n);
    chk("R10 rate 1 repeats", n, period(1));
    do_reset(3'd3, 1'b0);
    measure(400, 1'b0, n);
    chk("R10 rate 3 period", n, period(3));
    do_reset(3'd1, 1'b0);
    measure(200, 1'b1, n);
    chk("R10 only enabled ticks count", n, 2 * period(1) - 1);
  endtask

  task automatic t_relock();
    do_reset(3'd0, 1'b0);
    wr(8'h03); wr(8'h05);
    chk("R11 locked before reset", reg_rdata, 8'h03);
    do_reset(3'd0, 1'b0);
    wr(8'h05);
    chk("R11 reset releases lock", reg_rdata, 8'h05);
  endtask

  initial begin
    @(negedge clk);
    t_reset_boot();
    t_once();
    t_mask();
    t_zero_lock();
    t_dbg();
    t_special();
    t_normal_restart();
    t_src_restart();
    t_stop();
    t_rate();
    t_relock();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule